// File: doc/BRIEF.md
# NAND Bus Timing Generator

This block sits on the host side of a raw NAND flash bus. It turns single abstract requests into strobe waveforms with exact cycle counts. A request can issue one command byte, issue a run of address bytes, write a run of data bytes, read a run of data bytes, or wait for the device's ready line. All minimum setup, hold and pulse times are given in nanoseconds. They are turned into clock-cycle counts from the system clock period, which is itself a parameter.

The host offers a request on `req_valid_i` when `req_ready_o` is high. The request carries an operation code and a byte count minus one. Outgoing bytes are taken from `wr_data_i`. The block pulses `wr_take_o` once per byte it has latched, and the source then advances. Incoming bytes appear on `rd_data_o` together with a pulse on `rd_valid_o`. Every request ends with a one-cycle `done_o`. A ready wait that runs past `tmo_limit_i` also raises `tmo_err_o` in the same cycle as `done_o`. The operation codes are 0 = command, 1 = address, 2 = data write, 3 = data read and 4 = ready wait. Codes 5 to 7 only return `done_o` on the next cycle.

The write-strobe low width depends on the chip-enable setup chosen. When `CS_CYC*CLK_NS` is below 10 ns, the low width is stretched from 25 ns to 35 ns.

Top module: `nand_bus_timer`

## Requirements
- R1: While reset is asserted and right after it, chip enable, write strobe and read strobe are high. CLE, ALE, the I/O drive enable, `done_o`, `tmo_err_o`, `wr_take_o` and `rd_valid_o` are low, and `req_ready_o` is high.
- R2: A command request (code 0) pulls chip enable low for exactly `CS_CYC` cycles before the single write-strobe falling edge. During that strobe CLE is high and ALE is low. The length field is ignored.
- R3: An address request (code 1) with length field L gives exactly L+1 write strobes. ALE is high and CLE is low for every one of them.
- R4: A data write (code 2) with length field L gives L+1 write strobes with CLE and ALE low and the I/O driver enabled. The strobes carry the successive `wr_data_i` bytes in order. `wr_take_o` is high in the first low cycle of each strobe.
- R5: Every write strobe stays low for max(ceil(W/CLK_NS), ceil(20/CLK_NS)) cycles. W is 35 when `CS_CYC*CLK_NS` < 10 and 25 otherwise.
- R6: The write strobe stays high between strobes, and after the last strobe until `done_o`, for max(ceil(15/CLK_NS), ceil(10/CLK_NS), ceil(50/CLK_NS) - low width, 1) cycles.
- R7: A read (code 3) with length field L gives L+1 read strobes. Each is low for max(ceil(30/CLK_NS), ceil(25/CLK_NS)) cycles and high for max(ceil(15/CLK_NS), ceil(50/CLK_NS) - low width) cycles. The I/O driver stays off for the whole request. The bus value on the last low cycle's closing edge is returned on `rd_data_o` with `rd_valid_o` in the first high cycle.
- R8: Write and read strobes are never low together. While a write strobe is low, chip enable is low and CLE, ALE and `nand_io_o` stay stable.
- R9: A ready wait (code 4) passes the ready/busy line (high = ready) through a two-flop synchronizer. It ends with `done_o` on the third clock edge after the line rises, or on the first edge if the line is already settled high.
- R10: If ready is not seen, the wait ends with `done_o` and `tmo_err_o` on clock edge `tmo_limit_i`+1 after acceptance. When ready and the limit fall on the same edge, ready wins and no error is flagged.
- R11: `done_o` is a single-cycle pulse. In that cycle chip enable is already high and CLE, ALE and the driver enable are low. A request offered while `req_ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_op_i | input | 3 | Operation code |
| req_len_i | input | LEN_W | Byte count minus one |
| tmo_limit_i | input | TMO_W | Ready-wait cycle limit |
| wr_data_i | input | IO_W | Next outgoing byte |
| wr_take_o | output | 1 | Outgoing byte latched, advance source |
| rd_data_o | output | IO_W | Last byte read |
| rd_valid_o | output | 1 | rd_data_o updated |
| done_o | output | 1 | Request finished (one cycle) |
| tmo_err_o | output | 1 | Ready wait timed out (with done_o) |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_io_o | output | IO_W | Outgoing bus value |
| nand_io_oe_o | output | 1 | Drive enable for nand_io_o |
| nand_io_i | input | IO_W | Incoming bus value |
| nand_rb_i | input | 1 | Ready/busy, low = busy |

## Verification
The bench sweeps every operation over several byte counts on three clock/setup configurations. The first uses a 10 ns period. The second uses a 5 ns period with short chip-enable setup, so the strobe is stretched. The third uses a 5 ns period with long setup, where the cycle-time rule rather than the high-time rule sets the high width. Measuring low and high runs across these configurations separates the stretched pulse from the normal one, and separates the two competing high-width rules. Reads use a bus model that shows a corrupted value until just before the access time, so capture one cycle early shows up as wrong data. Ready waits put the rising edge before, inside and exactly at the limit, which separates the synchronizer latency and the ready-over-timeout priority.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;

  typedef enum logic [2:0] {
    OP_CMD  = 3'd0,
    OP_ADDR = 3'd1,
    OP_WR   = 3'd2,
    OP_RD   = 3'd3,
    OP_WAIT = 3'd4
  } nb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } nb_st_e;

  function automatic int cyc_of(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nand_dly_ctr.sv
module nand_dly_ctr #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rb_i,
  input  logic             clr_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             rdy_o,
  output logic             expire_o
);

  logic             s1_q, s2_q;
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rb_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign rdy_o    = s2_q;
  assign expire_o = (cnt_q == limit_i);

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !$past(clr_i)) |-> (cnt_q <= limit_i));

endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nand_bus_pkg::*;
#(
  parameter int IO_W        = 8,
  parameter int LEN_W       = 4,
  parameter int TMO_W       = 8,
  parameter int CLK_NS      = 10,
  parameter int CS_CYC      = 1,
  parameter int WP_NS       = 25,
  parameter int WP_LONG_NS  = 35,
  parameter int CS_SHORT_NS = 10,
  parameter int DS_NS       = 20,
  parameter int WH_NS       = 15,
  parameter int HOLD_NS     = 10,
  parameter int WC_NS       = 50,
  parameter int REA_NS      = 30,
  parameter int RP_NS       = 25,
  parameter int REH_NS      = 15,
  parameter int RC_NS       = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic [IO_W-1:0]  wr_data_i,
  output logic             wr_take_o,
  output logic [IO_W-1:0]  rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             tmo_err_o,
  output logic             nand_ce_n_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  output logic             nand_re_n_o,
  output logic [IO_W-1:0]  nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [IO_W-1:0]  nand_io_i,
  input  logic             nand_rb_i
);

  // short CE setup demands the longer write pulse
  localparam int WP_SEL = (CS_CYC * CLK_NS < CS_SHORT_NS) ? WP_LONG_NS : WP_NS;
  localparam int LO_W   = imax(imax(cyc_of(WP_SEL, CLK_NS), cyc_of(DS_NS, CLK_NS)), 1);
  localparam int HI_W   = imax(imax(cyc_of(WH_NS, CLK_NS), cyc_of(HOLD_NS, CLK_NS)),
                               imax(cyc_of(WC_NS, CLK_NS) - LO_W, 1));
  localparam int RL_W   = imax(imax(cyc_of(REA_NS, CLK_NS), cyc_of(RP_NS, CLK_NS)), 1);
  localparam int RH_W   = imax(imax(cyc_of(REH_NS, CLK_NS), cyc_of(RC_NS, CLK_NS) - RL_W), 1);
  localparam int MAXW   = imax(imax(imax(CS_CYC, LO_W), imax(HI_W, RL_W)), RH_W);
  localparam int CW     = $clog2(MAXW + 1);

  localparam logic [CW-1:0] CS_V = CW'(CS_CYC - 1);
  localparam logic [CW-1:0] LO_V = CW'(LO_W - 1);
  localparam logic [CW-1:0] HI_V = CW'(HI_W - 1);
  localparam logic [CW-1:0] RL_V = CW'(RL_W - 1);
  localparam logic [CW-1:0] RH_V = CW'(RH_W - 1);

  nb_st_e           st_q;
  nb_op_e           op_q;
  nb_op_e           op_in;
  logic [LEN_W-1:0] left_q;
  logic             is_rd;
  logic             ph_ld;
  logic [CW-1:0]    ph_val;
  logic             ph_zero;
  logic             rb_rdy, rb_expire;
  logic             bus_op_in;

  assign op_in       = nb_op_e'(req_op_i);
  assign is_rd       = (op_q == OP_RD);
  assign req_ready_o = (st_q == ST_IDLE);
  assign bus_op_in   = (op_in == OP_CMD) || (op_in == OP_ADDR) ||
                       (op_in == OP_WR)  || (op_in == OP_RD);

  always_comb begin
    ph_ld  = 1'b0;
    ph_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i && bus_op_in) begin
        ph_ld  = 1'b1;
        ph_val = CS_V;
      end
      ST_SETUP: if (ph_zero) begin
        ph_ld  = 1'b1;
        ph_val = is_rd ? RL_V : LO_V;
      end
      ST_LOW: if (ph_zero) begin
        ph_ld  = 1'b1;
        ph_val = is_rd ? RH_V : HI_V;
      end
      ST_HIGH: if (ph_zero && left_q != '0) begin
        ph_ld  = 1'b1;
        ph_val = is_rd ? RL_V : LO_V;
      end
      default: ;
    endcase
  end

  nand_dly_ctr #(.CW(CW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_ld),
    .val_i  (ph_val),
    .zero_o (ph_zero)
  );

  nand_rb_watch #(.TMO_W(TMO_W)) u_rb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rb_i     (nand_rb_i),
    .clr_i    (st_q != ST_WAIT),
    .limit_i  (tmo_limit_i),
    .rdy_o    (rb_rdy),
    .expire_o (rb_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      op_q         <= OP_CMD;
      left_q       <= '0;
      wr_take_o    <= 1'b0;
      rd_data_o    <= '0;
      rd_valid_o   <= 1'b0;
      done_o       <= 1'b0;
      tmo_err_o    <= 1'b0;
      nand_ce_n_o  <= 1'b1;
      nand_cle_o   <= 1'b0;
      nand_ale_o   <= 1'b0;
      nand_we_n_o  <= 1'b1;
      nand_re_n_o  <= 1'b1;
      nand_io_o    <= '0;
      nand_io_oe_o <= 1'b0;
    end else begin
      wr_take_o  <= 1'b0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      tmo_err_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          op_q   <= op_in;
          left_q <= (op_in == OP_CMD) ? '0 : req_len_i;
          if (bus_op_in) begin
            st_q         <= ST_SETUP;
            nand_ce_n_o  <= 1'b0;
            nand_cle_o   <= (op_in == OP_CMD);
            nand_ale_o   <= (op_in == OP_ADDR);
            nand_io_oe_o <= (op_in != OP_RD);
          end else if (op_in == OP_WAIT) begin
            st_q <= ST_WAIT;
          end else begin
            done_o <= 1'b1;
          end
        end
        ST_SETUP: if (ph_zero) begin
          st_q <= ST_LOW;
          if (is_rd) begin
            nand_re_n_o <= 1'b0;
          end else begin
            nand_we_n_o <= 1'b0;
            nand_io_o   <= wr_data_i;
            wr_take_o   <= 1'b1;
          end
        end
        ST_LOW: if (ph_zero) begin
          st_q        <= ST_HIGH;
          nand_we_n_o <= 1'b1;
          nand_re_n_o <= 1'b1;
          if (is_rd) begin
            rd_data_o  <= nand_io_i;
            rd_valid_o <= 1'b1;
          end
        end
        ST_HIGH: if (ph_zero) begin
          if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            st_q   <= ST_LOW;
            if (is_rd) begin
              nand_re_n_o <= 1'b0;
            end else begin
              nand_we_n_o <= 1'b0;
              nand_io_o   <= wr_data_i;
              wr_take_o   <= 1'b1;
            end
          end else begin
            st_q         <= ST_IDLE;
            done_o       <= 1'b1;
            nand_ce_n_o  <= 1'b1;
            nand_cle_o   <= 1'b0;
            nand_ale_o   <= 1'b0;
            nand_io_oe_o <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (rb_rdy) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else if (rb_expire) begin
            st_q      <= ST_IDLE;
            done_o    <= 1'b1;
            tmo_err_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // checker-side run length of the write strobe
  logic [CW:0] we_lo_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_lo_q <= '0;
    else if (!nand_we_n_o) we_lo_q <= we_lo_q + 1'b1;
    else                   we_lo_q <= '0;
  end

  // R5
  we_low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_n_o) |-> (we_lo_q == (CW+1)'(LO_W)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_n_o && !nand_re_n_o));

  // R8
  we_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_n_o |-> (!nand_ce_n_o && nand_io_oe_o && !(nand_cle_o && nand_ale_o)));

  // R8
  low_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_n_o && $past(!nand_we_n_o)) |->
      ($stable(nand_cle_o) && $stable(nand_ale_o) && $stable(nand_io_o)));

  // R7
  rd_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_n_o |-> !nand_io_oe_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  tmo_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> done_o);

endmodule

// File: tb/tb_nand_bus_timer.sv
`timescale 1ns/1ps
module tb_nand_bus_timer;

  localparam int NU = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       req_valid [NU];
  logic [2:0] req_op;
  logic [3:0] req_len;
  logic [7:0] tmo_limit;
  logic [7:0] wr_data;
  logic [7:0] io_in;
  logic       rb;

  logic       req_ready [NU];
  logic       wr_take   [NU];
  logic       rd_valid  [NU];
  logic       done      [NU];
  logic       tmo       [NU];
  logic       ce_n      [NU];
  logic       cle       [NU];
  logic       ale       [NU];
  logic       we_n      [NU];
  logic       re_n      [NU];
  logic       oe        [NU];
  logic [7:0] rd_data   [NU];
  logic [7:0] io_out    [NU];

  for (genvar g = 0; g < NU; g++) begin : gen_u
    nand_bus_timer #(
      .CLK_NS ((g == 0) ? 10 : 5),
      .CS_CYC ((g == 2) ? 2 : 1)
    ) dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid[g]),
      .req_ready_o  (req_ready[g]),
      .req_op_i     (req_op),
      .req_len_i    (req_len),
      .tmo_limit_i  (tmo_limit),
      .wr_data_i    (wr_data),
      .wr_take_o    (wr_take[g]),
      .rd_data_o    (rd_data[g]),
      .rd_valid_o   (rd_valid[g]),
      .done_o       (done[g]),
      .tmo_err_o    (tmo[g]),
      .nand_ce_n_o  (ce_n[g]),
      .nand_cle_o   (cle[g]),
      .nand_ale_o   (ale[g]),
      .nand_we_n_o  (we_n[g]),
      .nand_re_n_o  (re_n[g]),
      .nand_io_o    (io_out[g]),
      .nand_io_oe_o (oe[g]),
      .nand_io_i    (io_in),
      .nand_rb_i    (rb)
    );
  end

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rd_ix = 0;

  always @(posedge clk) cyc++;

  function automatic int cdiv(input int a, input int b); return (a + b - 1) / b; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int ck_of(input int u); return (u == 0) ? 10 : 5; endfunction
  function automatic int cs_of(input int u); return (u == 2) ? 2 : 1; endfunction
  function automatic int lo_of(input int u);
    int w = (cs_of(u) * ck_of(u) < 10) ? 35 : 25;
    return mx(cdiv(w, ck_of(u)), cdiv(20, ck_of(u)));
  endfunction
  function automatic int hi_of(input int u);
    int ck = ck_of(u);
    return mx(mx(cdiv(15, ck), cdiv(10, ck)), mx(cdiv(50, ck) - lo_of(u), 1));
  endfunction
  function automatic int rl_of(input int u);
    return mx(cdiv(30, ck_of(u)), cdiv(25, ck_of(u)));
  endfunction
  function automatic int rh_of(input int u);
    return mx(mx(cdiv(15, ck_of(u)), cdiv(50, ck_of(u)) - rl_of(u)), 1);
  endfunction
  function automatic logic [7:0] pat(input int k); return 8'((k * 37 + 11) & 255); endfunction
  function automatic logic [7:0] rdpat(input int k); return 8'((k * 29 + 90) & 255); endfunction

  // bus-side read model: garbage until just before access time
  always @(negedge re_n[0]) begin
    io_in = ~rdpat(rd_ix);
    #29;
    io_in = rdpat(rd_ix);
    rd_ix++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int u, input int op, input int len, input bit poke);
    int n = 0, lowrun = 0, hirun = 0, strobes = 0, idx = 0;
    int attr_err = 0, other_err = 0, stab_err = 0, oe_err = 0, extra = 0;
    int seed = op * 40 + len * 3 + u;
    int nexp = (op == 0) ? 1 : len + 1;
    bit rdop = (op == 3);
    logic s, os;
    logic [7:0] io_prev = '0;
    string rtag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R7";
    rd_ix   = 0;
    wr_data = pat(seed);
    @(negedge clk);
    req_op = 3'(op); req_len = 4'(len); req_valid[u] = 1'b1;
    @(negedge clk);
    req_valid[u] = 1'b0;
    while (!done[u] && n < 4000) begin
      if (poke && n == 2) req_valid[u] = 1'b1;
      if (poke && n == 3) req_valid[u] = 1'b0;
      s  = rdop ? re_n[u] : we_n[u];
      os = rdop ? we_n[u] : re_n[u];
      if (!os) other_err++;
      if (rdop && oe[u]) oe_err++;
      if (!s) begin
        if (lowrun == 0) begin
          if (strobes == 0) chk(hirun == cs_of(u), "R2 ce setup cycles", hirun, cs_of(u));
          else if (rdop)    chk(hirun == rh_of(u), "R7 re high width", hirun, rh_of(u));
          else              chk(hirun == hi_of(u), "R6 we high width", hirun, hi_of(u));
          hirun = 0;
          if (!rdop) begin
            chk(io_out[u] == pat(seed + strobes), {rtag, " byte order"}, io_out[u], pat(seed + strobes));
            chk(wr_take[u] == 1'b1, "R4 take pulse", wr_take[u], 1);
          end
        end else if (!rdop && io_out[u] != io_prev) stab_err++;
        io_prev = io_out[u];
        if (ce_n[u] || cle[u] != (op == 0) || ale[u] != (op == 1) || (!rdop && !oe[u])) attr_err++;
        lowrun++;
      end else begin
        if (lowrun > 0) begin
          if (rdop) chk(lowrun == rl_of(u), "R7 re low width", lowrun, rl_of(u));
          else      chk(lowrun == lo_of(u), "R5 we low width", lowrun, lo_of(u));
          strobes++;
          lowrun = 0;
          if (rdop) chk(rd_valid[u] && rd_data[u] == rdpat(strobes - 1), "R7 read data",
                        rd_data[u], rdpat(strobes - 1));
        end
        if (ce_n[u]) attr_err++;
        hirun++;
      end
      if (wr_take[u]) begin idx++; wr_data = pat(seed + idx); end
      @(negedge clk);
      n++;
    end
    chk(done[u] == 1'b1, "R11 done seen", done[u], 1);
    if (rdop) chk(hirun == rh_of(u), "R7 final high", hirun, rh_of(u));
    else      chk(hirun == hi_of(u), "R6 final high before done", hirun, hi_of(u));
    chk(strobes == nexp, {rtag, " strobe count"}, strobes, nexp);
    chk(ce_n[u] && !cle[u] && !ale[u] && !oe[u], "R11 release at done", ce_n[u], 1);
    chk(attr_err == 0, {rtag, " latch/enable levels"}, attr_err, 0);
    chk(other_err == 0, "R8 strobes exclusive", other_err, 0);
    chk(stab_err == 0, "R8 data stable in strobe", stab_err, 0);
    chk(oe_err == 0, "R7 driver off in read", oe_err, 0);
    @(negedge clk);
    chk(!done[u], "R11 done one cycle", done[u], 0);
    if (poke) begin
      for (int i = 0; i < 8; i++) begin
        if (!we_n[u] || done[u] || !ce_n[u]) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R11 request while busy ignored", extra, 0);
    end
  endtask

  task automatic run_wait(input int limit, input bit init_hi, input int d,
                          input int exp_diff, input bit exp_tmo, input string tag);
    int t0, k = 0, diff = -1;
    bit t = 1'b0;
    rb = init_hi;
    tmo_limit = 8'(limit);
    repeat (3) @(negedge clk);
    req_op = 3'd4; req_valid[0] = 1'b1;
    @(negedge clk);
    req_valid[0] = 1'b0;
    t0 = cyc;
    while (k < 1000) begin
      if (done[0]) begin diff = cyc - t0; t = tmo[0]; break; end
      if (d >= 0 && k == d) rb = 1'b1;
      @(negedge clk);
      k++;
    end
    chk(diff == exp_diff, {tag, " done latency"}, diff, exp_diff);
    chk(t == exp_tmo, {tag, " timeout flag"}, t, exp_tmo);
    rb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int u = 0; u < NU; u++) req_valid[u] = 1'b0;
    req_op = '0; req_len = '0; tmo_limit = '0; wr_data = '0; io_in = '0; rb = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      // R1
      chk(ce_n[u] && we_n[u] && re_n[u], "R1 strobes idle high", {ce_n[u], we_n[u], re_n[u]}, 7);
      chk(!cle[u] && !ale[u] && !oe[u] && !done[u] && !tmo[u] && !wr_take[u] && !rd_valid[u],
          "R1 outputs low", 1, 0);
      chk(req_ready[u], "R1 ready", req_ready[u], 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready[0] && ce_n[0], "R1 idle after reset", req_ready[0], 1);

    for (int u = 0; u < NU; u++) begin
      run_op(u, 0, 5, 1'b0);                       // R2 length ignored
      for (int l = 0; l < 5; l++) run_op(u, 1, l, 1'b0);
      for (int l = 0; l < 8; l++) run_op(u, 2, l, 1'b0);
    end
    for (int l = 0; l < 8; l++) run_op(0, 3, l, 1'b0);
    run_op(0, 2, 0, 1'b1);

    run_wait(50, 1'b1, -1, 1, 1'b0, "R9 already ready");
    run_wait(50, 1'b0, 0, 3, 1'b0, "R9 rise at once");
    run_wait(50, 1'b0, 4, 7, 1'b0, "R9 rise later");
    run_wait(6, 1'b0, -1, 7, 1'b1, "R10 timeout");
    run_wait(0, 1'b0, -1, 1, 1'b1, "R10 zero limit");
    run_wait(8, 1'b0, 6, 9, 1'b0, "R10 ready wins tie");
    run_wait(8, 1'b0, 7, 9, 1'b1, "R10 ready one late");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule